// File: doc/BRIEF.md
# Voice Interrupt Status Stack

This block holds pending per-voice interrupt events for a wavetable synthesizer until the host collects them. Each event names the voice that raised it and says whether the voice reached the end of its sample (wave end), the end of its volume ramp (ramp end), or both. Events are kept last-in-first-out: the host always sees the most recent pending event first.

The host reads a source byte that describes the event on top of the stack. A read strobe removes that event at the clock edge it is sampled on. The stack also supplies the wave and ramp bits of the global interrupt status byte, which always mirror the top entry. It assembles that byte together with the timer, MIDI and DMA sources that other logic provides. An interrupt-request line is raised while events are pending. Each source read drops the line for one cycle, and the line returns if events remain.

The request line comes from a three-state controller. `ST_IDLE` means the stack is empty and the request is low. `ST_ASSERT` means events are pending and the request is high. `ST_RELEASE` is the one-cycle gap after a source read, with the request low. The transitions are:
- `ST_IDLE` goes to `ST_ASSERT` on a push.
- Any state goes to `ST_RELEASE` on a read.
- `ST_RELEASE` goes to `ST_ASSERT` when entries remain or a push arrives.
- `ST_RELEASE` goes to `ST_IDLE` otherwise.
- A clear sends every state to `ST_IDLE`.

Top module: `voice_irq_stack`

## Requirements
- R1: Entries are returned in last-in-first-out order. The voice number and both flags come back exactly as pushed.
- R2: The stack holds exactly DEPTH entries. All DEPTH entries are returned by DEPTH reads, newest first.
- R3: A push while the stack holds DEPTH entries, with no read in the same cycle, is discarded and leaves the contents unchanged. `ovf` is high for exactly the following cycle.
- R4: In the cycle after an accepted push, `wave_pend` and `ramp_pend` equal the pushed flags, and `src_byte[4:0]` equals the pushed voice.
- R5: In the cycle after a read, `wave_pend` and `ramp_pend` equal the flags of the new top entry, or are both 0 when the stack is empty.
- R6: `src_byte` describes the current top entry:
  - bit 7 = NOT wave flag;
  - bit 6 = NOT ramp flag;
  - bit 5 = 1;
  - bits 4:0 = voice number.
  
  The host samples it in the cycle in which `pop` is high, and the entry is removed at that clock edge.
- R7: A read of an empty stack returns `8'hE0` (voice 0, neither flag) and leaves the stack empty.
- R8: `stat_byte` has this layout:
  - bit 0 = `midi_tx_irq`;
  - bit 1 = `midi_rx_irq`;
  - bit 2 = `tmr1_irq`;
  - bit 3 = `tmr2_irq`;
  - bit 4 = 0;
  - bit 5 = wave pending;
  - bit 6 = ramp pending;
  - bit 7 = `dma_tc_irq`.
- R9: `clr` empties the stack and overrides any push or read in the same cycle. In the next cycle `irq`, `ovf`, `wave_pend` and `ramp_pend` are 0.
- R10: `irq` is high in the cycle after any cycle that ends with at least one entry stored and has no read and no clear.
- R11: `irq` is low in the cycle after a read. It is high again one cycle later if entries remain and no further read occurs.
- R12: A push and a read in the same cycle act as read-then-push: the top entry is replaced, and the push is accepted even when the stack is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous board reset; empties the stack |
| push_vld | input | 1 | Push an event this cycle |
| push_voice | input | 5 | Voice number of the pushed event |
| push_wave | input | 1 | Wave-end flag of the pushed event |
| push_ramp | input | 1 | Ramp-end flag of the pushed event |
| pop | input | 1 | Source-byte read strobe; removes the top entry |
| midi_tx_irq | input | 1 | MIDI transmit interrupt source |
| midi_rx_irq | input | 1 | MIDI receive interrupt source |
| tmr1_irq | input | 1 | Timer 1 interrupt source |
| tmr2_irq | input | 1 | Timer 2 interrupt source |
| dma_tc_irq | input | 1 | DMA terminal-count interrupt source |
| src_byte | output | 8 | Formatted top entry |
| stat_byte | output | 8 | Global interrupt status byte |
| wave_pend | output | 1 | Wave flag of top entry |
| ramp_pend | output | 1 | Ramp flag of top entry |
| irq | output | 1 | Interrupt request |
| ovf | output | 1 | Discarded-push pulse |

## Verification
Two functions can fall in the same cycle: a push arriving with a source read, and a clear arriving with either of them. The bench provokes both on purpose. It pushes while reading on a full stack, on a partly filled stack and on an empty one. It also asserts clear together with a push and together with a read. A queue model applies each cycle as clear first, then read, then push. It judges the source byte in the read cycle, and the request, overflow and status bits in the following cycle.

// File: rtl/vstk_pkg.sv
package vstk_pkg;
    localparam int VOICE_W = 5;

    typedef struct packed {
        logic               wave;
        logic               ramp;
        logic [VOICE_W-1:0] voice;
    } vevt_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ASSERT  = 2'd1,
        ST_RELEASE = 2'd2
    } irq_st_e;
endpackage

// File: rtl/vstk_store.sv
module vstk_store
    import vstk_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  vevt_t         wr_data,
    output vevt_t         top,
    output logic [CW-1:0] occ,
    output logic          empty,
    output logic          full
);
    logic [CW-1:0] occ_q;
    vevt_t         slots_q [DEPTH];
    logic [CW-1:0] top_slot;
    logic [CW-1:0] wr_slot;

    // A simultaneous read frees the top slot, so the write lands on it.
    always_comb begin
        top_slot = occ_q - CW'(1);
        wr_slot  = rd_en ? top_slot : occ_q;
        empty    = (occ_q == '0);
        full     = (occ_q == CW'(DEPTH));
        top      = empty ? '0 : slots_q[top_slot[AW-1:0]];
        occ      = occ_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots_q[wr_slot[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            occ_q <= '0;
        end else begin
            unique case ({wr_en, rd_en})
                2'b10:   occ_q <= occ_q + CW'(1);
                2'b01:   occ_q <= occ_q - CW'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end
endmodule

// File: rtl/vstk_ctrl.sv
module vstk_ctrl
    import vstk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push_vld,
    input  logic pop,
    input  logic empty,
    input  logic full,
    output logic wr_en,
    output logic rd_en,
    output logic irq,
    output logic ovf
);
    irq_st_e state_q, state_d;
    logic    drop_push;

    always_comb begin
        rd_en     = pop && !empty && !clr;
        wr_en     = push_vld && !clr && (!full || rd_en);
        drop_push = push_vld && !clr && full && !rd_en;
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (pop) state_d = ST_RELEASE;
                            else if (push_vld) state_d = ST_ASSERT;
                ST_ASSERT:  if (pop) state_d = ST_RELEASE;
                ST_RELEASE: if (pop) state_d = ST_RELEASE;
                            else if (!empty || push_vld) state_d = ST_ASSERT;
                            else state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == ST_ASSERT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= drop_push;
    end
endmodule

// File: rtl/vstk_fmt.sv
module vstk_fmt
    import vstk_pkg::*;
(
    input  vevt_t       top,
    input  logic        midi_tx_irq,
    input  logic        midi_rx_irq,
    input  logic        tmr1_irq,
    input  logic        tmr2_irq,
    input  logic        dma_tc_irq,
    output logic [7:0]  src_byte,
    output logic [7:0]  stat_byte,
    output logic        wave_pend,
    output logic        ramp_pend
);
    always_comb begin
        wave_pend = top.wave;
        ramp_pend = top.ramp;
        // Source byte encodes an absent flag as a set bit.
        src_byte  = {~top.wave, ~top.ramp, 1'b1, top.voice};
        stat_byte = {dma_tc_irq, top.ramp, top.wave, 1'b0,
                     tmr2_irq, tmr1_irq, midi_rx_irq, midi_tx_irq};
    end
endmodule

// File: rtl/voice_irq_stack.sv
module voice_irq_stack
    import vstk_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push_vld,
    input  logic [VOICE_W-1:0] push_voice,
    input  logic               push_wave,
    input  logic               push_ramp,
    input  logic               pop,
    input  logic               midi_tx_irq,
    input  logic               midi_rx_irq,
    input  logic               tmr1_irq,
    input  logic               tmr2_irq,
    input  logic               dma_tc_irq,
    output logic [7:0]         src_byte,
    output logic [7:0]         stat_byte,
    output logic               wave_pend,
    output logic               ramp_pend,
    output logic               irq,
    output logic               ovf
);
    vevt_t         push_evt;
    vevt_t         top;
    logic [CW-1:0] occ;
    logic          empty;
    logic          full;
    logic          wr_en;
    logic          rd_en;

    always_comb begin
        push_evt.wave  = push_wave;
        push_evt.ramp  = push_ramp;
        push_evt.voice = push_voice;
    end

    vstk_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push_vld(push_vld), .pop(pop),
        .empty(empty), .full(full), .wr_en(wr_en), .rd_en(rd_en),
        .irq(irq), .ovf(ovf)
    );

    vstk_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(push_evt), .top(top), .occ(occ), .empty(empty), .full(full)
    );

    vstk_fmt u_fmt (
        .top(top), .midi_tx_irq(midi_tx_irq), .midi_rx_irq(midi_rx_irq),
        .tmr1_irq(tmr1_irq), .tmr2_irq(tmr2_irq), .dma_tc_irq(dma_tc_irq),
        .src_byte(src_byte), .stat_byte(stat_byte),
        .wave_pend(wave_pend), .ramp_pend(ramp_pend)
    );
endmodule

// File: rtl/vstk_checker.sv
module vstk_checker #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          push_vld,
    input logic [4:0]    push_voice,
    input logic          push_wave,
    input logic          push_ramp,
    input logic          pop,
    input logic [7:0]    src_byte,
    input logic          wave_pend,
    input logic          ramp_pend,
    input logic          irq,
    input logic          ovf,
    input logic [CW-1:0] occ
);
    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH) && push_vld && !pop && !clr) |=> (ovf && $stable(occ)));

    p_push_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && !clr && (occ != CW'(DEPTH) || pop)) |=>
        (wave_pend == $past(push_wave) && ramp_pend == $past(push_ramp) &&
         src_byte[4:0] == $past(push_voice)));

    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && pop && !push_vld && !clr) |=> (occ == '0));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0 && !irq && !ovf && !wave_pend && !ramp_pend));

    p_irq_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !irq);

    p_irq_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && occ != '0 && !pop && !clr) |=> irq);
endmodule

bind voice_irq_stack vstk_checker #(.DEPTH(DEPTH)) u_vstk_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_vld(push_vld),
    .push_voice(push_voice), .push_wave(push_wave), .push_ramp(push_ramp),
    .pop(pop), .src_byte(src_byte), .wave_pend(wave_pend),
    .ramp_pend(ramp_pend), .irq(irq), .ovf(ovf), .occ(occ)
);

// File: tb/test_voice_irq_stack.sv
`timescale 1ns/1ps
module test_voice_irq_stack;
    import vstk_pkg::*;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0, push_vld = 1'b0, push_wave = 1'b0, push_ramp = 1'b0, pop = 1'b0;
    logic [4:0] push_voice = '0;
    logic       midi_tx_irq = 1'b0, midi_rx_irq = 1'b0, tmr1_irq = 1'b0, tmr2_irq = 1'b0, dma_tc_irq = 1'b0;
    logic [7:0] src_byte, stat_byte;
    logic       wave_pend, ramp_pend, irq, ovf;

    int    n_chk = 0;
    int    n_err = 0;
    vevt_t model [$];
    logic  exp_irq = 1'b0, exp_ovf = 1'b0;
    logic  prev_pop = 1'b0, prev_push = 1'b0, prev_clr = 1'b0;

    always #4 clk = ~clk;

    voice_irq_stack #(.DEPTH(DEPTH)) i_voice_irq_stack (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push_vld(push_vld),
        .push_voice(push_voice), .push_wave(push_wave), .push_ramp(push_ramp),
        .pop(pop), .midi_tx_irq(midi_tx_irq), .midi_rx_irq(midi_rx_irq),
        .tmr1_irq(tmr1_irq), .tmr2_irq(tmr2_irq), .dma_tc_irq(dma_tc_irq),
        .src_byte(src_byte), .stat_byte(stat_byte), .wave_pend(wave_pend),
        .ramp_pend(ramp_pend), .irq(irq), .ovf(ovf)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one cycle of stimulus, applied 2 ns after the rising edge.
    task automatic drive(input bit ps, input logic [4:0] v, input bit w, input bit r,
                         input bit pp, input bit c);
        @(posedge clk);
        #2;
        push_vld = ps; push_voice = v; push_wave = w; push_ramp = r;
        pop = pp; clr = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 5'd0, 0, 0, 0, 0);
    endtask

    // Monitor / scoreboard: compares at the falling edge, then applies the
    // cycle to the model as clear, then read, then push.
    always @(negedge clk) begin
        if (!rst_n) begin
            model.delete();
            exp_irq = 1'b0; exp_ovf = 1'b0;
            prev_pop = 1'b0; prev_push = 1'b0; prev_clr = 1'b0;
        end else begin
            vevt_t       t;
            logic [7:0]  exp_src, exp_stat;
            string       tg;
            t = (model.size() != 0) ? model[$] : '0;
            exp_src  = {~t.wave, ~t.ramp, 1'b1, t.voice};
            exp_stat = {dma_tc_irq, t.ramp, t.wave, 1'b0, tmr2_irq, tmr1_irq, midi_rx_irq, midi_tx_irq};

            if (pop && push_vld)                       tg = "R12";
            else if (pop && model.size() == DEPTH)     tg = "R2";
            else if (pop && model.size() == 0)         tg = "R7";
            else if (pop)                              tg = "R1";
            else                                       tg = "R6";
            chk(src_byte == exp_src, tg, src_byte, exp_src);
            if (pop && model.size() == 0) chk(src_byte == 8'hE0, "R7", src_byte, 8'hE0);

            tg = prev_clr ? "R9" : (prev_push ? "R4" : "R5");
            chk({wave_pend, ramp_pend} == {t.wave, t.ramp}, tg,
                {6'd0, wave_pend, ramp_pend}, {6'd0, t.wave, t.ramp});
            chk(stat_byte == exp_stat, "R8", stat_byte, exp_stat);
            tg = prev_clr ? "R9" : (prev_pop ? "R11" : "R10");
            chk(irq == exp_irq, tg, {7'd0, irq}, {7'd0, exp_irq});
            chk(ovf == exp_ovf, prev_clr ? "R9" : "R3", {7'd0, ovf}, {7'd0, exp_ovf});

            prev_pop = pop; prev_push = push_vld; prev_clr = clr;
            if (clr) begin
                model.delete();
                exp_irq = 1'b0; exp_ovf = 1'b0;
            end else begin
                if (pop && model.size() != 0) void'(model.pop_back());
                exp_ovf = 1'b0;
                if (push_vld) begin
                    if (model.size() < DEPTH) model.push_back({push_wave, push_ramp, push_voice});
                    else exp_ovf = 1'b1;
                end
                exp_irq = !pop && (model.size() != 0);
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);                                     // reset state: R6 R10
        // R1: LIFO order, R11 back-to-back reads
        drive(1, 5'd3, 1, 0, 0, 0);
        drive(1, 5'd7, 0, 1, 0, 0);
        drive(1, 5'd12, 1, 1, 0, 0);
        drive(0, 5'd0, 0, 0, 1, 0);
        drive(0, 5'd0, 0, 0, 1, 0);
        drive(0, 5'd0, 0, 0, 1, 0);
        idle(2);
        drive(0, 5'd0, 0, 0, 1, 0);                  // R7: empty read
        idle(2);
        // R2 R3: fill, overflow, R12 push+read while full
        midi_tx_irq = 1; tmr2_irq = 1; dma_tc_irq = 1; // R8 pattern
        for (int i = 0; i < DEPTH; i++) drive(1, 5'(20 + i), i[0], i[1], 0, 0);
        drive(1, 5'd31, 1, 1, 0, 0);
        idle(1);
        drive(1, 5'd9, 0, 1, 1, 0);
        // R11: spaced reads let the request return
        for (int i = 0; i < DEPTH; i++) begin
            drive(0, 5'd0, 0, 0, 1, 0);
            idle(2);
        end
        midi_tx_irq = 0; tmr2_irq = 0; dma_tc_irq = 0;
        midi_rx_irq = 1; tmr1_irq = 1;
        // R9: clear with push, clear with read
        drive(1, 5'd1, 1, 0, 0, 0);
        drive(1, 5'd2, 0, 1, 0, 0);
        drive(1, 5'd5, 1, 1, 0, 1);
        idle(1);
        drive(1, 5'd6, 1, 0, 0, 0);
        drive(0, 5'd0, 0, 0, 1, 1);
        idle(2);
        // R12: push and read together on an empty stack
        drive(1, 5'd17, 0, 1, 1, 0);
        idle(2);
        drive(0, 5'd0, 0, 0, 1, 0);
        idle(1);
        // Mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            midi_tx_irq = lfsr[9]; midi_rx_irq = lfsr[10]; tmr1_irq = lfsr[11];
            tmr2_irq = lfsr[12]; dma_tc_irq = lfsr[13];
            drive(lfsr[0] | lfsr[1], lfsr[8:4], lfsr[2], lfsr[3],
                  lfsr[14] & lfsr[7], lfsr[15:11] == 5'h1F);
        end
        idle(3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule